// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the 12-bit program counter of a small 4-bit controller core and computes its next value every cycle. It serves a program space of 3K bytes, from 000h up to BFFh. An instruction decoder sits outside the block and issues one command per cycle. The command tells the block to advance by one or two bytes, take a page-relative or an absolute branch on the status flag, enter a subroutine through the fixed short-call table or through an 11-bit absolute target, return, return from an interrupt service routine, or accept the lowest-addressed pending interrupt.

Return addresses are held in a register array inside the block, indexed by a 4-bit level pointer. A push first decrements the pointer. A return reads the entry the pointer names and then increments it. Software sets the pointer before the first call, because reset leaves it untouched. When an interrupt is accepted, the current flags are stored next to the return address. An interrupt return hands those flags back and gives a one-cycle pulse that re-enables interrupts.

Top module: `pcu_core`

## Requirements
- R1: While `rst` is high, `pc_o` becomes 000h, `flags_o` becomes 0 and `ei_set_o` becomes 0. These values are visible after the clock edge.
- R2: Command codes are NOP=0, INC1=1, INC2=2, SBR=3, LBR=4, SCALL=5, LCALL=6, RET=7, RETI=8 and IRQ=9. NOP holds the PC. INC1 adds 1 and INC2 adds 2, modulo 4096.
- R3: SBR with `status`=1 sets PC to the upper six bits of PC+1 concatenated with `field[5:0]`. Bits `field[11:6]` are ignored. SBR with `status`=0 sets PC to PC+1.
- R4: LBR with `status`=1 loads all 12 bits of `field`. LBR with `status`=0 sets PC to PC+2.
- R5: SCALL with n=`field[3:0]` jumps to 8n+6 when n is 1 to 15, and to 086h when n=0.
- R6: LCALL jumps to `field[10:0]`, and PC bit 11 is forced to 0.
- R7: SCALL pushes PC+1 and LCALL pushes PC+2. Each push decrements `sp_o` by one and writes the entry at the new level.
- R8: RET loads PC from the entry at level `sp_o`, then increments `sp_o`. It leaves `flags_o` unchanged and does not pulse `ei_set_o`.
- R9: `irq_req` bit order is bit0=INT0, bit1=timer A, bit2=timer B, bit3=time base, bit4=INT1. IRQ takes the lowest set bit and jumps to 002h, 006h, 008h, 00Ah or 00Ch respectively. It pushes the current PC together with `flags_in`. IRQ with no bit set changes nothing.
- R10: RETI restores PC and `sp_o` in the same way as RET. It also drives the flags saved with that entry onto `flags_o`, and pulses `ei_set_o` high for exactly one cycle.
- R11: `sp_we` loads `sp_wdata` into the level pointer. In the same cycle it overrides any push or pop adjustment. Reset does not change the pointer.
- R12: Up to 13 nested pushes return in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 4 | Decoded next-address command |
| field | input | 12 | Address or index field from the instruction |
| status | input | 1 | Branch condition flag |
| flags_in | input | 4 | Current flags, saved on interrupt acceptance |
| irq_req | input | 5 | Pending interrupt requests, bit0 has highest priority |
| sp_we | input | 1 | Level pointer write strobe |
| sp_wdata | input | 4 | Level pointer write value |
| pc_o | output | 12 | Registered program counter |
| sp_o | output | 4 | Current level pointer |
| flags_o | output | 4 | Flags restored by the last interrupt return |
| ei_set_o | output | 1 | One-cycle interrupt-enable set pulse |

## Verification
The properties assume two things about the inputs. First, the level pointer has been loaded through `sp_we` before the first push or pop. Second, the nesting depth stays within thirteen levels, so that no return reads an entry that was never written. The bench meets both conditions. It writes the pointer to 13 before every call and interrupt sequence, and it never issues a return without a matching earlier push. Every command code it drives is a defined one. The sweeps cover all 64 short-branch fields at page-edge PCs, all 16 short-call indices, and all 32 interrupt request patterns.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_INC1  = 4'd1,
    CMD_INC2  = 4'd2,
    CMD_SBR   = 4'd3,
    CMD_LBR   = 4'd4,
    CMD_SCALL = 4'd5,
    CMD_LCALL = 4'd6,
    CMD_RET   = 4'd7,
    CMD_RETI  = 4'd8,
    CMD_IRQ   = 4'd9
  } pcu_cmd_e;
endpackage

// File: rtl/pcu_irq_pick.sv
module pcu_irq_pick #(
  parameter int IRQ_N = 5,
  parameter int PC_W  = 12
) (
  input  logic [IRQ_N-1:0] req,
  output logic             any,
  output logic [PC_W-1:0]  vec
);
  // Source 0 sits at 002h; later sources start at 006h, two bytes apart.
  function automatic logic [PC_W-1:0] vec_of(input int idx);
    return (idx == 0) ? PC_W'(2) : PC_W'(2 * idx + 4);
  endfunction

  always_comb begin
    any = |req;
    vec = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (req[i]) vec = vec_of(i);
    end
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int PC_W    = 12,
  parameter int SBR_W   = 6,
  parameter int SCALL_W = 4
) (
  input  pcu_cmd_e        cmd,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] field,
  input  logic            status,
  input  logic            irq_any,
  input  logic [PC_W-1:0] irq_vec,
  input  logic [PC_W-1:0] ret_addr,
  output logic [PC_W-1:0] next_pc,
  output logic [PC_W-1:0] push_addr,
  output logic            push,
  output logic            pop,
  output logic            reti
);
  localparam logic [PC_W-1:0] SCALL_WRAP = PC_W'((1 << (SCALL_W + 3)) + 6);

  logic [PC_W-1:0]    pc1, pc2, scall_tgt;
  logic [SCALL_W-1:0] idx;

  assign pc1 = pc + PC_W'(1);
  assign pc2 = pc + PC_W'(2);
  assign idx = field[SCALL_W-1:0];
  assign scall_tgt = (idx == '0) ? SCALL_WRAP : PC_W'({idx, 3'b110});

  always_comb begin
    next_pc   = pc;
    push_addr = pc1;
    push      = 1'b0;
    pop       = 1'b0;
    reti      = 1'b0;
    unique case (cmd)
      CMD_INC1:  next_pc = pc1;
      CMD_INC2:  next_pc = pc2;
      CMD_SBR:   next_pc = status ? {pc1[PC_W-1:SBR_W], field[SBR_W-1:0]} : pc1;
      CMD_LBR:   next_pc = status ? field : pc2;
      CMD_SCALL: begin
        next_pc   = scall_tgt;
        push_addr = pc1;
        push      = 1'b1;
      end
      CMD_LCALL: begin
        next_pc   = {1'b0, field[PC_W-2:0]};
        push_addr = pc2;
        push      = 1'b1;
      end
      CMD_RET: begin
        next_pc = ret_addr;
        pop     = 1'b1;
      end
      CMD_RETI: begin
        next_pc = ret_addr;
        pop     = 1'b1;
        reti    = 1'b1;
      end
      CMD_IRQ: begin
        push_addr = pc;
        push      = irq_any;
        next_pc   = irq_any ? irq_vec : pc;
      end
      default: next_pc = pc;
    endcase
  end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int SP_W = 4,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            push,
  input  logic            pop,
  input  logic            sp_we,
  input  logic [SP_W-1:0] sp_wdata,
  input  logic [DW-1:0]   wdata,
  output logic [SP_W-1:0] sp_q,
  output logic [DW-1:0]   top
);
  localparam int DEPTH = 1 << SP_W;

  logic [DW-1:0]   mem [DEPTH];
  logic [SP_W-1:0] wr_ptr;

  assign wr_ptr = sp_q - SP_W'(1);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  // Level pointer is deliberately left without reset.
  always_ff @(posedge clk) begin
    if (sp_we)     sp_q <= sp_wdata;
    else if (push) sp_q <= wr_ptr;
    else if (pop)  sp_q <= sp_q + SP_W'(1);
  end

  assign top = mem[sp_q];
endmodule

// File: rtl/pcu_core.sv
module pcu_core
  import pcu_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int SP_W   = 4,
  parameter int FLAG_W = 4,
  parameter int IRQ_N  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cmd,
  input  logic [PC_W-1:0]   field,
  input  logic              status,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic              sp_we,
  input  logic [SP_W-1:0]   sp_wdata,
  output logic [PC_W-1:0]   pc_o,
  output logic [SP_W-1:0]   sp_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              ei_set_o
);
  localparam int DW = PC_W + FLAG_W;

  pcu_cmd_e        cmd_e;
  logic            irq_any, push, pop, reti;
  logic [PC_W-1:0] irq_vec, next_pc, push_addr;
  logic [DW-1:0]   top;

  assign cmd_e = pcu_cmd_e'(cmd);

  pcu_irq_pick #(.IRQ_N(IRQ_N), .PC_W(PC_W)) pick_i (
    .req(irq_req), .any(irq_any), .vec(irq_vec)
  );

  pcu_target #(.PC_W(PC_W)) tgt_i (
    .cmd(cmd_e), .pc(pc_o), .field(field), .status(status),
    .irq_any(irq_any), .irq_vec(irq_vec), .ret_addr(top[PC_W-1:0]),
    .next_pc(next_pc), .push_addr(push_addr), .push(push), .pop(pop), .reti(reti)
  );

  pcu_ret_stack #(.SP_W(SP_W), .DW(DW)) stk_i (
    .clk(clk), .push(push), .pop(pop), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .wdata({flags_in, push_addr}), .sp_q(sp_o), .top(top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o     <= '0;
      flags_o  <= '0;
      ei_set_o <= 1'b0;
    end else begin
      pc_o     <= next_pc;
      ei_set_o <= reti;
      if (reti) flags_o <= top[DW-1:PC_W];
    end
  end
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk
  import pcu_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int SP_W   = 4,
  parameter int FLAG_W = 4,
  parameter int IRQ_N  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cmd,
  input logic [PC_W-1:0]   field,
  input logic              status,
  input logic [IRQ_N-1:0]  irq_req,
  input logic              sp_we,
  input logic [PC_W-1:0]   pc_o,
  input logic [SP_W-1:0]   sp_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              ei_set_o
);
  localparam int SBR_W = 6;

  logic            rst_d = 1'b0;
  logic [PC_W-1:0] inc1;

  assign inc1 = pc_o + PC_W'(1);

  always @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_state_R1: assert (pc_o == '0 && flags_o == '0 && !ei_set_o)
        else $error("reset state wrong");
    end
  end

  assert_inc1_R2: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_INC1 |=> pc_o == $past(inc1));

  assert_sbr_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SBR && status) |=>
      (pc_o[SBR_W-1:0] == $past(field[SBR_W-1:0]) &&
       pc_o[PC_W-1:SBR_W] == $past(inc1[PC_W-1:SBR_W])));

  assert_lbr_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LBR && status) |=> pc_o == $past(field));

  assert_lcall_low_R6: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_LCALL |=> !pc_o[PC_W-1]);

  assert_push_dec_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LCALL && !sp_we) |=> sp_o == SP_W'($past(sp_o) - 1'b1));

  assert_int0_vec_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_IRQ && irq_req[0]) |=> pc_o == PC_W'(2));

  assert_reti_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_RETI |=> ei_set_o);

  assert_pulse_source_R10: assert property (@(posedge clk) disable iff (rst)
    ei_set_o |-> $past(cmd) == CMD_RETI);
endmodule

bind pcu_core pcu_chk #(.PC_W(PC_W), .SP_W(SP_W), .FLAG_W(FLAG_W), .IRQ_N(IRQ_N)) chk_i (
  .clk(clk), .rst(rst), .cmd(cmd), .field(field), .status(status),
  .irq_req(irq_req), .sp_we(sp_we), .pc_o(pc_o), .sp_o(sp_o),
  .flags_o(flags_o), .ei_set_o(ei_set_o)
);

// File: tb/pcu_core_tb_top.sv
module pcu_core_tb_top;
  import pcu_pkg::*;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cmd = 4'd0;
  logic [11:0] field = '0;
  logic        status = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [4:0]  irq_req = '0;
  logic        sp_we = 1'b0;
  logic [3:0]  sp_wdata = '0;
  logic [11:0] pc_o;
  logic [3:0]  sp_o;
  logic [3:0]  flags_o;
  logic        ei_set_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [11:0] exp_pc;
  logic [3:0]  exp_sp;
  logic [3:0]  exp_fl;
  logic [15:0] mstk [16];

  always #(CLK_P/2) clk = ~clk;

  pcu_core dut_i (
    .clk(clk), .rst(rst), .cmd(cmd), .field(field), .status(status),
    .flags_in(flags_in), .irq_req(irq_req), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .pc_o(pc_o), .sp_o(sp_o), .flags_o(flags_o), .ei_set_o(ei_set_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [11:0] f, input logic st,
                       input logic [3:0] fl, input logic [4:0] rq,
                       input logic we, input logic [3:0] wd);
    cmd = c; field = f; status = st; flags_in = fl; irq_req = rq;
    sp_we = we; sp_wdata = wd;
    @(posedge clk); #1;
    cmd = CMD_NOP; sp_we = 1'b0; irq_req = '0;
  endtask

  task automatic do_setsp(input logic [3:0] v);
    apply(CMD_NOP, 12'h0, 1'b0, 4'h0, 5'h0, 1'b1, v);
    exp_sp = v;
    chk("R11 sp write", sp_o, exp_sp);
    chk("R2 nop hold", pc_o, exp_pc);
  endtask

  task automatic do_lbr(input logic [11:0] f, input logic st);
    apply(CMD_LBR, f, st, 4'h0, 5'h0, 1'b0, 4'h0);
    exp_pc = st ? f : exp_pc + 12'd2;
    chk("R4 lbr", pc_o, exp_pc);
  endtask

  task automatic do_sbr(input logic [11:0] f, input logic st);
    logic [11:0] p1;
    p1 = exp_pc + 12'd1;
    apply(CMD_SBR, f, st, 4'h0, 5'h0, 1'b0, 4'h0);
    exp_pc = st ? {p1[11:6], f[5:0]} : p1;
    chk("R3 sbr", pc_o, exp_pc);
  endtask

  task automatic do_inc(input logic two);
    apply(two ? CMD_INC2 : CMD_INC1, 12'h0, 1'b0, 4'h0, 5'h0, 1'b0, 4'h0);
    exp_pc = exp_pc + (two ? 12'd2 : 12'd1);
    chk("R2 inc", pc_o, exp_pc);
  endtask

  task automatic do_scall(input logic [3:0] n);
    apply(CMD_SCALL, {8'hA5, n}, 1'b0, 4'h0, 5'h0, 1'b0, 4'h0);
    exp_sp = exp_sp - 4'd1;
    mstk[exp_sp] = {4'h0, exp_pc + 12'd1};
    exp_pc = (n == 0) ? 12'h086 : 12'(8 * n + 6);
    chk("R5 scall target", pc_o, exp_pc);
    chk("R7 scall sp", sp_o, exp_sp);
  endtask

  task automatic do_lcall(input logic [11:0] f);
    apply(CMD_LCALL, f, 1'b0, 4'h0, 5'h0, 1'b0, 4'h0);
    exp_sp = exp_sp - 4'd1;
    mstk[exp_sp] = {4'h0, exp_pc + 12'd2};
    exp_pc = {1'b0, f[10:0]};
    chk("R6 lcall target", pc_o, exp_pc);
    chk("R7 lcall sp", sp_o, exp_sp);
  endtask

  task automatic do_ret(input string tag);
    apply(CMD_RET, 12'h0, 1'b0, 4'h0, 5'h0, 1'b0, 4'h0);
    exp_pc = mstk[exp_sp][11:0];
    exp_sp = exp_sp + 4'd1;
    chk({tag, " ret pc"}, pc_o, exp_pc);
    chk("R8 ret sp", sp_o, exp_sp);
    chk("R8 ret flags kept", flags_o, exp_fl);
    chk("R8 ret no pulse", ei_set_o, 1'b0);
  endtask

  task automatic do_irq(input logic [4:0] rq, input logic [3:0] fl);
    apply(CMD_IRQ, 12'h0, 1'b0, fl, rq, 1'b0, 4'h0);
    if (rq != 0) begin
      exp_sp = exp_sp - 4'd1;
      mstk[exp_sp] = {fl, exp_pc};
      for (int i = 4; i >= 0; i--) begin
        if (rq[i]) exp_pc = (i == 0) ? 12'h002 : 12'(2 * i + 4);
      end
    end
    chk("R9 irq vector", pc_o, exp_pc);
    chk("R9 irq sp", sp_o, exp_sp);
  endtask

  task automatic do_reti;
    apply(CMD_RETI, 12'h0, 1'b0, 4'h0, 5'h0, 1'b0, 4'h0);
    exp_pc = mstk[exp_sp][11:0];
    exp_fl = mstk[exp_sp][15:12];
    exp_sp = exp_sp + 4'd1;
    chk("R10 reti pc", pc_o, exp_pc);
    chk("R10 reti sp", sp_o, exp_sp);
    chk("R10 reti flags", flags_o, exp_fl);
    chk("R10 reti pulse", ei_set_o, 1'b1);
    apply(CMD_NOP, 12'h0, 1'b0, 4'h0, 5'h0, 1'b0, 4'h0);
    chk("R10 pulse one cycle", ei_set_o, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_pc = '0; exp_sp = '0; exp_fl = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pc", pc_o, 12'h000);
    chk("R1 reset flags", flags_o, 4'h0);
    chk("R1 reset pulse", ei_set_o, 1'b0);
    rst = 1'b0;

    do_setsp(4'd13);
    for (int i = 0; i < 5; i++) do_inc(i[0]);
    do_lbr(12'hFFF, 1'b1);
    do_inc(1'b0);
    do_lbr(12'hFFE, 1'b1);
    do_inc(1'b1);

    // Page-relative branch sweep over page-edge PCs.
    foreach (exp_fl[k]) begin : unused_loop_guard
    end
    for (int p = 0; p < 5; p++) begin
      for (int f = 0; f < 64; f++) begin
        for (int s = 0; s < 2; s++) begin
          case (p)
            0: do_lbr(12'h000, 1'b1);
            1: do_lbr(12'h03F, 1'b1);
            2: do_lbr(12'h7BF, 1'b1);
            3: do_lbr(12'hBFE, 1'b1);
            default: do_lbr(12'h5A5, 1'b1);
          endcase
          do_sbr({6'h2A ^ 6'(f), 6'(f)}, s[0]);
        end
      end
    end

    for (int i = 0; i < 4; i++) begin
      do_lbr(12'h123 * 12'(i + 1), 1'b1);
      do_lbr(12'hFFF, 1'b0);
    end

    for (int n = 0; n < 16; n++) begin
      do_setsp(4'd13);
      do_lbr(12'h300 + 12'(n), 1'b1);
      do_scall(4'(n));
      do_ret("R7");
      chk("R7 short call return addr", pc_o, 12'h301 + 12'(n));
    end

    for (int t = 0; t < 6; t++) begin
      do_setsp(4'd13);
      do_lbr(12'hB00 + 12'(t * 3), 1'b1);
      do_lcall(12'hFFF - 12'(t * 300));
      do_ret("R7");
      chk("R7 long call return addr", pc_o, 12'hB02 + 12'(t * 3));
    end

    for (int r = 0; r < 32; r++) begin
      do_setsp(4'd13);
      do_lbr(12'h400 + 12'(r * 5), 1'b1);
      do_irq(5'(r), 4'(r) ^ 4'h9);
      if (r != 0) begin
        do_reti();
        chk("R9 irq return to interrupted pc", pc_o, 12'h400 + 12'(r * 5));
      end
    end

    // Thirteen nested levels, mixing calls and interrupts.
    do_setsp(4'd13);
    do_lbr(12'h010, 1'b1);
    for (int l = 0; l < 13; l++) begin
      if (l % 3 == 2) do_irq(5'(1 << (l % 5)), 4'(l));
      else do_lcall(12'(l * 97 + 5));
    end
    chk("R12 pointer after 13 pushes", sp_o, 4'd0);
    for (int l = 12; l >= 0; l--) begin
      if (l % 3 == 2) do_reti();
      else do_ret("R12");
    end
    chk("R12 pointer restored", sp_o, 4'd13);
    chk("R12 first return point", pc_o, 12'h012);

    // Pointer write wins over a push in the same cycle.
    do_setsp(4'd9);
    do_lbr(12'h222, 1'b1);
    apply(CMD_LCALL, 12'h155, 1'b0, 4'h0, 5'h0, 1'b1, 4'd3);
    chk("R11 write overrides push", sp_o, 4'd3);
    chk("R6 lcall with write", pc_o, 12'h155);

    // Reset leaves the pointer untouched.
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R11 pointer kept over reset", sp_o, 4'd3);
    chk("R1 reset pc again", pc_o, 12'h000);
    rst = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule